// File: doc/BRIEF.md
# Cache Maintenance Control Unit

This block is the register-mapped front end of a data cache maintenance engine. Software programs it through a simple 32-bit register bus: an enable bit, a full-invalidate request, a 3-bit command code, a start bit, and first and last line addresses of a range. A three-state sequencer (`ST_IDLE`, `ST_FULL`, `ST_LINE`) turns accepted requests into operations on a cache-side request/acknowledge port. The cache arrays, the tag lookup and the write-back master all sit behind that port.

In `ST_IDLE` a pending full-invalidate request takes priority and moves the sequencer to `ST_FULL`. Otherwise a pending start moves it to `ST_LINE`, or, if the range is empty, finishes at once without leaving `ST_IDLE`. `ST_FULL` holds one request with op code 100 until it is acknowledged, then returns to `ST_IDLE`. `ST_LINE` issues one request per 16-byte line from the first line to the last, stepping the line cursor on each acknowledge. It returns to `ST_IDLE` on the acknowledge of the last line.

The status flags are busy, done and error. Each done and error flag is cleared by writing 1 to the flag clear register. Each flag can raise the interrupt when its enable bit is set.

Top module: `cmaint_ctrl`

## Requirements
- R1: After reset every readable register is 0, `irq` is 0 and `cport_req` is 0.
- R2: Control bit 0 is the enable. A write of 1 to control bit 1 (full invalidate) is accepted only if the enable was already 1 before that write. Writing 0 to bit 1 has no effect.
- R3: One cycle after a full-invalidate request is accepted, status bit 0 (full busy) rises and control bit 1 reads 0. The port then carries op 100 until it is acknowledged.
- R4: On the acknowledge of the full invalidation, status bit 0 falls and status bit 1 (full done) sets on the same edge.
- R5: Control bit 11 (start) is accepted only if the enable was already 1, status bits 0 and 3 are both 0, and the written code in bits 10:8 is 001, 010 or 011. Otherwise it is ignored. The start bit reads 0 again once status bit 3 (command busy) rises.
- R6: A started command issues exactly one request per line, in ascending order, from the first line to the last line inclusive. Each request carries `cport_op` equal to the code (001 clean, 010 invalidate, 011 clean and invalidate) and `cport_line` equal to address bits 31:4.
- R7: If the last line is below the first line, status bit 4 (command done) sets, no request is issued and status bit 3 stays 0.
- R8: Writes to the code field (control bits 10:8) have no effect while status bit 3 is 1.
- R9: Any acknowledge that comes with `cport_err` sets status bit 2 (error). The range walk still continues to its last line.
- R10: Writing 1 to bit 1, 2 or 4 of the flag clear register (0x0C) clears the status flag at the same bit. Writing 0 has no effect. If a set event and a clear for the same flag fall on the same edge, the flag stays 1.
- R11: `irq` is the OR of status bits 1, 2 and 4, each ANDed with bit 1, 2 or 4 of the interrupt enable register (0x08).
- R12: The registers read back at these offsets: control 0x00, status 0x04, interrupt enable 0x08, first line 0x28, last line 0x2C. The two range registers keep bits 31:4 only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| cport_req | output | 1 | Cache-side operation request |
| cport_op | output | 3 | Operation: 001/010/011 line op, 100 full invalidate |
| cport_line | output | 28 | Line address (address bits 31:4) |
| cport_ack | input | 1 | Operation done, sampled while `cport_req` is 1 |
| cport_err | input | 1 | Write-back error, valid with `cport_ack` |
| irq | output | 1 | Interrupt |

## Verification
The assertions assume two things about the cache port. Once `cport_req` is high it stays high with a stable line until acknowledged, and software leaves the range registers unchanged while status bit 3 is set. The stimulus keeps within both. The bench's cache model acknowledges only while a request is present, and only after a fixed latency: four cycles for a full invalidation and a programmable count for a line. The bench programs the range registers only while the sequencer is idle. It injects errors only on acknowledges of clean operations.

// File: rtl/cmaint_pkg.sv
package cmaint_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_FULL, ST_LINE} seq_state_t;

    localparam logic [2:0] OP_CLEAN = 3'b001;
    localparam logic [2:0] OP_INVAL = 3'b010;
    localparam logic [2:0] OP_CLINV = 3'b011;
    localparam logic [2:0] OP_FULL  = 3'b100;

    localparam logic [7:0] OFS_CTRL = 8'h00;
    localparam logic [7:0] OFS_STAT = 8'h04;
    localparam logic [7:0] OFS_IEN  = 8'h08;
    localparam logic [7:0] OFS_FCLR = 8'h0C;
    localparam logic [7:0] OFS_LO   = 8'h28;
    localparam logic [7:0] OFS_HI   = 8'h2C;
endpackage

// File: rtl/cmaint_seq.sv
module cmaint_seq
    import cmaint_pkg::*;
#(
    parameter int LINE_W = 28
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inv_pend,
    input  logic              cmd_pend,
    input  logic [2:0]        cmd_code,
    input  logic [LINE_W-1:0] rng_lo,
    input  logic [LINE_W-1:0] rng_hi,
    input  logic              port_ack,
    input  logic              port_err,
    output logic              take_inv,
    output logic              take_cmd,
    output logic              inv_busy,
    output logic              cmd_busy,
    output logic              ev_inv_done,
    output logic              ev_cmd_done,
    output logic              ev_err,
    output logic              port_req,
    output logic [2:0]        port_op,
    output logic [LINE_W-1:0] port_line
);
    seq_state_t        state_q, state_d;
    logic [LINE_W-1:0] cur_q;
    logic              ld_cur, adv_cur;

    // state register and line cursor
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cur_q   <= '0;
        end else begin
            state_q <= state_d;
            if (ld_cur)       cur_q <= rng_lo;
            else if (adv_cur) cur_q <= cur_q + 1'b1;
        end
    end

    // next state and outputs
    always_comb begin
        state_d     = state_q;
        ld_cur      = 1'b0;
        adv_cur     = 1'b0;
        take_inv    = 1'b0;
        take_cmd    = 1'b0;
        inv_busy    = 1'b0;
        cmd_busy    = 1'b0;
        ev_inv_done = 1'b0;
        ev_cmd_done = 1'b0;
        ev_err      = 1'b0;
        port_req    = 1'b0;
        port_op     = 3'b000;
        port_line   = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (inv_pend) begin
                    take_inv = 1'b1;
                    state_d  = ST_FULL;
                end else if (cmd_pend) begin
                    take_cmd = 1'b1;
                    if (rng_hi < rng_lo) begin
                        ev_cmd_done = 1'b1;
                    end else begin
                        ld_cur  = 1'b1;
                        state_d = ST_LINE;
                    end
                end
            end
            ST_FULL: begin
                inv_busy = 1'b1;
                port_req = 1'b1;
                port_op  = OP_FULL;
                if (port_ack) begin
                    ev_inv_done = 1'b1;
                    ev_err      = port_err;
                    state_d     = ST_IDLE;
                end
            end
            ST_LINE: begin
                cmd_busy  = 1'b1;
                port_req  = 1'b1;
                port_op   = cmd_code;
                port_line = cur_q;
                if (port_ack) begin
                    ev_err = port_err;
                    if (cur_q == rng_hi) begin
                        ev_cmd_done = 1'b1;
                        state_d     = ST_IDLE;
                    end else begin
                        adv_cur = 1'b1;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // R6: a waiting request holds its line
    p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        port_req && !port_ack |=> port_req && $stable(port_line));

    // R6: walked lines stay inside the programmed range
    p_line_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_busy |-> (port_line >= rng_lo) && (port_line <= rng_hi));
endmodule

// File: rtl/cmaint_regs.sv
module cmaint_regs
    import cmaint_pkg::*;
#(
    parameter int LINE_OFS = 4,
    localparam int LINE_W = 32 - LINE_OFS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [7:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              take_inv,
    input  logic              take_cmd,
    input  logic              inv_busy,
    input  logic              cmd_busy,
    input  logic              ev_inv_done,
    input  logic              ev_cmd_done,
    input  logic              ev_err,
    output logic              inv_pend,
    output logic              cmd_pend,
    output logic [2:0]        cmd_code,
    output logic [LINE_W-1:0] rng_lo,
    output logic [LINE_W-1:0] rng_hi,
    output logic              irq
);
    logic       en_q;
    logic       f_inv_done, f_err, f_cmd_done;
    logic [2:0] ien_q;   // {cmd done, error, full done}
    logic       wr_ctrl, wr_fclr, code_ok;

    assign wr_ctrl = bus_we && (bus_addr == OFS_CTRL);
    assign wr_fclr = bus_we && (bus_addr == OFS_FCLR);
    assign code_ok = (bus_wdata[10:8] == OP_CLEAN) || (bus_wdata[10:8] == OP_INVAL)
                  || (bus_wdata[10:8] == OP_CLINV);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q       <= 1'b0;
            inv_pend   <= 1'b0;
            cmd_pend   <= 1'b0;
            cmd_code   <= 3'b000;
            rng_lo     <= '0;
            rng_hi     <= '0;
            ien_q      <= 3'b000;
            f_inv_done <= 1'b0;
            f_err      <= 1'b0;
            f_cmd_done <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                en_q <= bus_wdata[0];
                if (!cmd_busy) cmd_code <= bus_wdata[10:8];
            end
            if (take_inv)                             inv_pend <= 1'b0;
            else if (wr_ctrl && bus_wdata[1] && en_q) inv_pend <= 1'b1;
            if (take_cmd)
                cmd_pend <= 1'b0;
            else if (wr_ctrl && bus_wdata[11] && en_q && !inv_busy && !cmd_busy && code_ok)
                cmd_pend <= 1'b1;
            if (bus_we && bus_addr == OFS_LO)  rng_lo <= bus_wdata[31:LINE_OFS];
            if (bus_we && bus_addr == OFS_HI)  rng_hi <= bus_wdata[31:LINE_OFS];
            if (bus_we && bus_addr == OFS_IEN) ien_q  <= {bus_wdata[4], bus_wdata[2], bus_wdata[1]};
            // set beats clear
            if (ev_inv_done)                    f_inv_done <= 1'b1;
            else if (wr_fclr && bus_wdata[1])   f_inv_done <= 1'b0;
            if (ev_err)                         f_err      <= 1'b1;
            else if (wr_fclr && bus_wdata[2])   f_err      <= 1'b0;
            if (ev_cmd_done)                    f_cmd_done <= 1'b1;
            else if (wr_fclr && bus_wdata[4])   f_cmd_done <= 1'b0;
        end
    end

    assign irq = (f_inv_done && ien_q[0]) || (f_err && ien_q[1]) || (f_cmd_done && ien_q[2]);

    always_comb begin
        unique case (bus_addr)
            OFS_CTRL: bus_rdata = {20'b0, cmd_pend, cmd_code, 6'b0, inv_pend, en_q};
            OFS_STAT: bus_rdata = {27'b0, f_cmd_done, cmd_busy, f_err, f_inv_done, inv_busy};
            OFS_IEN:  bus_rdata = {27'b0, ien_q[2], 1'b0, ien_q[1], ien_q[0], 1'b0};
            OFS_LO:   bus_rdata = {rng_lo, {LINE_OFS{1'b0}}};
            OFS_HI:   bus_rdata = {rng_hi, {LINE_OFS{1'b0}}};
            default:  bus_rdata = 32'b0;
        endcase
    end

    p_inv_needs_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(inv_pend) |-> $past(en_q));

    p_start_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_busy) |-> !cmd_pend);

    p_inv_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(inv_busy) |-> !inv_pend);

    p_full_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(inv_busy) |-> f_inv_done);

    p_code_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_busy && $past(cmd_busy) |-> $stable(cmd_code));

    p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ev_cmd_done |=> f_cmd_done);
endmodule

// File: rtl/cmaint_ctrl.sv
module cmaint_ctrl
    import cmaint_pkg::*;
#(
    parameter int LINE_OFS = 4,
    localparam int LINE_W = 32 - LINE_OFS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [7:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              cport_req,
    output logic [2:0]        cport_op,
    output logic [LINE_W-1:0] cport_line,
    input  logic              cport_ack,
    input  logic              cport_err,
    output logic              irq
);
    logic              take_inv, take_cmd, inv_busy, cmd_busy;
    logic              ev_inv_done, ev_cmd_done, ev_err;
    logic              inv_pend, cmd_pend;
    logic [2:0]        cmd_code;
    logic [LINE_W-1:0] rng_lo, rng_hi;

    cmaint_regs #(.LINE_OFS(LINE_OFS)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .take_inv(take_inv), .take_cmd(take_cmd), .inv_busy(inv_busy), .cmd_busy(cmd_busy),
        .ev_inv_done(ev_inv_done), .ev_cmd_done(ev_cmd_done), .ev_err(ev_err),
        .inv_pend(inv_pend), .cmd_pend(cmd_pend), .cmd_code(cmd_code),
        .rng_lo(rng_lo), .rng_hi(rng_hi), .irq(irq)
    );

    cmaint_seq #(.LINE_W(LINE_W)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .inv_pend(inv_pend), .cmd_pend(cmd_pend), .cmd_code(cmd_code),
        .rng_lo(rng_lo), .rng_hi(rng_hi),
        .port_ack(cport_ack), .port_err(cport_err),
        .take_inv(take_inv), .take_cmd(take_cmd),
        .inv_busy(inv_busy), .cmd_busy(cmd_busy),
        .ev_inv_done(ev_inv_done), .ev_cmd_done(ev_cmd_done), .ev_err(ev_err),
        .port_req(cport_req), .port_op(cport_op), .port_line(cport_line)
    );
endmodule

// File: tb/sim_cmaint_ctrl.sv
`timescale 1ns/1ps
module sim_cmaint_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        cport_req;
    logic [2:0]  cport_op;
    logic [27:0] cport_line;
    logic        cport_ack = 1'b0;
    logic        cport_err = 1'b0;
    logic        irq;

    always #2.5 clk = ~clk;

    cmaint_ctrl u0 (.*);

    typedef struct packed { logic [2:0] op; logic [27:0] line; } item_t;
    item_t exp_q[$];
    int    n_tests = 0, n_fail = 0, n_req = 0, lat = 2, cnt = 0;
    bit    inj_err = 1'b0, finished = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_stat(input logic [31:0] mask, input logic [31:0] val, input string tag);
        logic [31:0] s;
        for (int i = 0; i < 300; i++) begin
            rd(8'h04, s);
            if ((s & mask) == val) return;
        end
        chk(1'b0, tag, s & mask, val);
    endtask

    task automatic push_range(input logic [2:0] op, input logic [27:0] lo, input logic [27:0] hi);
        for (logic [28:0] l = {1'b0, lo}; l <= {1'b0, hi}; l++) exp_q.push_back({op, l[27:0]});
    endtask

    // cache model and scoreboard monitor
    always @(negedge clk) begin
        if (cport_ack) begin
            cport_ack = 1'b0; cport_err = 1'b0; cnt = 0;
        end else if (cport_req) begin
            cnt++;
            if (cnt >= ((cport_op == 3'b100) ? 4 : lat)) begin
                item_t got, want;
                cport_ack = 1'b1;
                cport_err = inj_err && cport_op[0];
                n_req++;
                got = {cport_op, cport_line};
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R6 unexpected request", {1'b0, got}, 32'h0);
                end else begin
                    want = exp_q.pop_front();
                    chk(got == want, "R6/R3 request op+line", {1'b0, got}, {1'b0, want});
                end
            end
        end
    end

    initial begin
        #(5.0 * 100000);
        if (!finished) begin
            chk(1'b0, "watchdog", 32'h0, 32'h1);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int snap;
        repeat (3) @(negedge clk);
        // R1 reset state
        rd(8'h00, d); chk(d == 0, "R1 control", d, 0);
        rd(8'h04, d); chk(d == 0, "R1 status", d, 0);
        chk(irq == 0 && cport_req == 0, "R1 irq/req", {irq, cport_req}, 0);
        rst_n = 1'b1;
        // R12 range registers keep bits 31:4
        wr(8'h28, 32'h0000_0105); rd(8'h28, d); chk(d == 32'h100, "R12 first line", d, 32'h100);
        wr(8'h2C, 32'h0000_020F); rd(8'h2C, d); chk(d == 32'h200, "R12 last line", d, 32'h200);
        // R2 full invalidate ignored while disabled
        wr(8'h00, 32'h2); rd(8'h00, d); chk(d == 0, "R2 inv ignored when disabled", d, 0);
        // R5 start ignored while disabled (code still written)
        wr(8'h00, 32'h900); rd(8'h00, d); chk(d == 32'h100, "R5 start ignored when disabled", d, 32'h100);
        wr(8'h00, 32'h1);
        // R5 reserved code 100 rejects start
        snap = n_req;
        wr(8'h00, 32'hC01); rd(8'h00, d); chk(d == 32'h401, "R5 bad code", d, 32'h401);
        repeat (8) @(negedge clk);
        chk(n_req == snap, "R5 no request for bad code", n_req, snap);
        // R3/R4 full invalidate
        exp_q.push_back({3'b100, 28'h0});
        wr(8'h00, 32'h403);
        rd(8'h04, d); chk(d[0] == 1, "R3 full busy rises", d, 1);
        rd(8'h00, d); chk(d[1] == 0, "R3 request bit cleared", d[1], 0);
        wait_stat(32'h1, 32'h0, "R4 full busy falls");
        rd(8'h04, d); chk(d[1] == 1, "R4 full done set", d, 32'h2);
        // R11/R10 interrupt and clearing
        chk(irq == 0, "R11 irq masked", irq, 0);
        wr(8'h08, 32'h2); #1 chk(irq == 1, "R11 irq on full done", irq, 1);
        wr(8'h0C, 32'h0); rd(8'h04, d); chk(d[1] == 1, "R10 zero write no effect", d, 32'h2);
        wr(8'h0C, 32'h2); rd(8'h04, d); chk(d[1] == 0 && irq == 0, "R10 clear full done", d, 0);
        // R6 clean walk over 4 lines, R8/R5 while busy
        lat = 3;
        wr(8'h28, 32'h1000); wr(8'h2C, 32'h1030);
        push_range(3'b001, 28'h100, 28'h103);
        snap = n_req;
        wr(8'h00, 32'h901);
        wait_stat(32'h8, 32'h8, "R6 command busy");
        wr(8'h00, 32'hA01); rd(8'h00, d); chk(d == 32'h101, "R8/R5 code frozen, start ignored", d, 32'h101);
        wait_stat(32'h10, 32'h10, "R6 command done");
        chk(n_req - snap == 4 && exp_q.size() == 0, "R6 four lines issued", n_req - snap, 4);
        // R9 error keeps walking
        inj_err = 1'b1; lat = 1;
        wr(8'h0C, 32'h16); wr(8'h08, 32'h4);
        wr(8'h28, 32'h2000); wr(8'h2C, 32'h2010);
        push_range(3'b011, 28'h200, 28'h201);
        wr(8'h00, 32'hB01);
        wait_stat(32'h18, 32'h10, "R9 command done");
        rd(8'h04, d); chk(d[2] == 1 && irq == 1, "R9 error flag and irq", d, 32'h14);
        chk(exp_q.size() == 0, "R9 walk completed", exp_q.size(), 0);
        inj_err = 1'b0;
        wr(8'h0C, 32'h16); rd(8'h04, d); chk(d == 0, "R10 clear all", d, 0);
        // R7 empty range
        wr(8'h28, 32'h200); wr(8'h2C, 32'h100);
        snap = n_req;
        wr(8'h00, 32'hA01);
        repeat (4) @(negedge clk);
        rd(8'h04, d); chk(d == 32'h10, "R7 done without busy", d, 32'h10);
        rd(8'h00, d); chk(d[11] == 0, "R7 start cleared", d[11], 0);
        chk(n_req == snap, "R7 no request", n_req, snap);
        // R10 set wins over clear on the same edge
        wr(8'h0C, 32'h10); lat = 3;
        wr(8'h28, 32'h400); wr(8'h2C, 32'h400);
        exp_q.push_back({3'b010, 28'h40});
        wr(8'h00, 32'hA01);
        for (int i = 0; i < 50; i++) begin
            @(negedge clk); #1;
            if (cport_ack && cport_req) break;
        end
        bus_we = 1'b1; bus_addr = 8'h0C; bus_wdata = 32'h10;
        @(negedge clk); bus_we = 1'b0;
        rd(8'h04, d); chk(d[4] == 1, "R10 set wins", d, 32'h10);
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule